// File: doc/BRIEF.md
# Two-Key Region Write Guard

This block sits in front of a byte-wide memory that is split into two regions: a program region at the top of the address space and a data region below it. Each region stays write-protected until software writes two fixed byte values, in the right order, to that region's key register. Writes aimed at a region that is still protected never reach the memory. The block drives this gating itself.

Software talks to the block through a small register port. It has one key register per region and a status register. The status register shows which regions are open. Software can use it to close a region again, but never to open one. A wrong key value puts that region's key machine into a failure state. Only a reset clears that state. The key constants, the address split and the bus widths are parameters.

Top module: `region_key_guard`

## Requirements
- R1: After reset both regions are locked: `prog_unlocked` and `data_unlocked` are 0 and no memory write is passed through.
- R2: With the program region locked, a write of `PKEY1` to the program key register (`reg_sel` = 0) followed by a write of `PKEY2` raises `prog_unlocked` on the clock edge that takes the second write.
- R3: The data region opens the same way through its own key register (`reg_sel` = 1), using `DKEY1` then `DKEY2`. Key writes to one region never change the other region's state.
- R4: A key write that does not match the expected value moves that region to a failed state. This applies both in the locked state and after the first key. In the failed state the region stays locked and ignores every key write, including a correct sequence. Status writes do not clear the failed state either.
- R5: A read of either key register returns 0. A read of the status register (`reg_sel` = 2) returns the program unlock flag in bit 1 and the data unlock flag in bit 3, with all other bits 0. A read with `reg_sel` = 3 returns 0, and a write with `reg_sel` = 3 has no effect.
- R6: A status write with bit 1 clear relocks the program region and discards a pending first key. A status write with bit 3 clear does the same for the data region. A status write with a bit set never unlocks a region.
- R7: A memory write request at an address at or above `SPLIT` (default 0x8000) is passed to `mem_wr_en` only while the program region is unlocked. A request below `SPLIT` is passed only while the data region is unlocked. Address and data pass through unchanged, and a blocked write is dropped.
- R8: A reset clears the failed state, after which the correct key sequence unlocks the region again.
- R9: Key writes to a region that is already unlocked have no effect; the region stays unlocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 program key, 1 data key, 2 status, 3 unused |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data for `reg_sel` |
| mem_wr_req | input | 1 | Memory write request |
| mem_addr | input | ADDR_W | Memory write address |
| mem_wdata | input | DATA_W | Memory write data |
| mem_wr_en | output | 1 | Gated memory write enable |
| mem_wr_addr | output | ADDR_W | Memory write address to the array |
| mem_wr_data | output | DATA_W | Memory write data to the array |
| prog_unlocked | output | 1 | Program region open |
| data_unlocked | output | 1 | Data region open |

## Verification
Register writes take effect on the clock edge that samples them, so an unlock flag changes at that same edge. A relock or failure shows on `prog_unlocked`, `data_unlocked` and the status read in the next cycle. `reg_rdata` and the gated memory write path are combinational: they follow the current inputs and the current lock state within the same cycle. The bench applies each cycle's inputs on the falling edge and compares every output against its model one time unit later. It advances the model only at the rising edge, so every comparison sees the state that the previous edge produced.

// File: rtl/region_key_guard.sv
module region_key_guard #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] SPLIT = 'h8000,
  parameter logic [DATA_W-1:0] PKEY1 = 8'h56,
  parameter logic [DATA_W-1:0] PKEY2 = 8'hAE,
  parameter logic [DATA_W-1:0] DKEY1 = 8'hAE,
  parameter logic [DATA_W-1:0] DKEY2 = 8'h56,
  parameter int PBIT = 1,
  parameter int DBIT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_sel,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              mem_wr_req,
  input  logic [ADDR_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_wdata,
  output logic              mem_wr_en,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [DATA_W-1:0] mem_wr_data,
  output logic              prog_unlocked,
  output logic              data_unlocked
);
  localparam logic [1:0] SEL_PKEY = 2'd0;
  localparam logic [1:0] SEL_DKEY = 2'd1;
  localparam logic [1:0] SEL_STAT = 2'd2;

  typedef enum logic [1:0] {KS_LOCKED, KS_FIRST, KS_OPEN, KS_FAIL} kstate_t;

  kstate_t pst, dst;

  function automatic kstate_t next_key(kstate_t cur, logic hit, logic relock,
                                       logic [DATA_W-1:0] v,
                                       logic [DATA_W-1:0] k1,
                                       logic [DATA_W-1:0] k2);
    if (cur == KS_FAIL) return KS_FAIL;
    if (hit) begin
      case (cur)
        KS_LOCKED: return (v == k1) ? KS_FIRST : KS_FAIL;
        KS_FIRST:  return (v == k2) ? KS_OPEN  : KS_FAIL;
        default:   return cur;
      endcase
    end
    if (relock) return KS_LOCKED;
    return cur;
  endfunction

  wire p_hit    = reg_wr && reg_sel == SEL_PKEY;
  wire d_hit    = reg_wr && reg_sel == SEL_DKEY;
  wire stat_wr  = reg_wr && reg_sel == SEL_STAT;
  wire p_relock = stat_wr && !reg_wdata[PBIT];
  wire d_relock = stat_wr && !reg_wdata[DBIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pst <= KS_LOCKED;
      dst <= KS_LOCKED;
    end else begin
      pst <= next_key(pst, p_hit, p_relock, reg_wdata, PKEY1, PKEY2);
      dst <= next_key(dst, d_hit, d_relock, reg_wdata, DKEY1, DKEY2);
    end
  end

  assign prog_unlocked = (pst == KS_OPEN);
  assign data_unlocked = (dst == KS_OPEN);

  always_comb begin
    reg_rdata = '0;
    if (reg_sel == SEL_STAT) begin
      reg_rdata[PBIT] = prog_unlocked;
      reg_rdata[DBIT] = data_unlocked;
    end
  end

  wire hi_region = (mem_addr >= SPLIT);
  assign mem_wr_en   = mem_wr_req && (hi_region ? prog_unlocked : data_unlocked);
  assign mem_wr_addr = mem_addr;
  assign mem_wr_data = mem_wdata;

  a_r1_reset_locked: assert property (@(posedge clk)
    !rst_n |=> (pst == KS_LOCKED && dst == KS_LOCKED));
  a_r2_prog_open_from_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prog_unlocked) |-> ($past(pst) == KS_FIRST && $past(p_hit)));
  a_r3_data_open_from_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_unlocked) |-> ($past(dst) == KS_FIRST && $past(d_hit)));
  a_r4_prog_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    pst == KS_FAIL |=> pst == KS_FAIL);
  a_r4_data_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    dst == KS_FAIL |=> dst == KS_FAIL);
  a_r5_key_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    reg_sel != SEL_STAT |-> reg_rdata == '0);
  a_r6_status_cannot_open: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && !prog_unlocked) |=> !prog_unlocked);
  a_r7_hi_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_addr >= SPLIT && !prog_unlocked) |-> !mem_wr_en);
  a_r7_lo_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_addr < SPLIT && !data_unlocked) |-> !mem_wr_en);
  a_r9_open_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_unlocked && !p_relock) |=> prog_unlocked);
endmodule

// File: tb/tb_region_key_guard.sv
module tb_region_key_guard;
  logic clk = 0, rst_n = 0;
  logic reg_wr = 0; logic [1:0] reg_sel = 0; logic [7:0] reg_wdata = 0;
  logic [7:0] reg_rdata;
  logic mem_wr_req = 0; logic [15:0] mem_addr = 0; logic [7:0] mem_wdata = 0;
  logic mem_wr_en; logic [15:0] mem_wr_addr; logic [7:0] mem_wr_data;
  logic prog_unlocked, data_unlocked;

  region_key_guard dut (.*);

  always #4 clk = ~clk;

  int errors = 0, checks = 0;
  int pm = 0, dm = 0;
  int unsigned lcg = 32'h1234_5678;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int key_next(int s, int v, int k1, int k2);
    if (s == 3) return 3;
    if (s == 0) return (v == k1) ? 1 : 3;
    if (s == 1) return (v == k2) ? 2 : 3;
    return s;
  endfunction

  task automatic step(bit wr, int sel, int wd, bit mreq, int addr);
    int exp_rd, exp_en;
    @(negedge clk);
    reg_wr = wr; reg_sel = sel[1:0]; reg_wdata = wd[7:0];
    mem_wr_req = mreq; mem_addr = addr[15:0]; mem_wdata = wd[7:0] ^ 8'h5A;
    #1;
    chk("R2 prog_unlocked", prog_unlocked, pm == 2);
    chk("R3 data_unlocked", data_unlocked, dm == 2);
    exp_rd = (sel == 2) ? (((pm == 2) ? 2 : 0) | ((dm == 2) ? 8 : 0)) : 0;
    chk("R5 reg_rdata", reg_rdata, exp_rd);
    exp_en = mreq && ((addr >= 'h8000) ? (pm == 2) : (dm == 2));
    chk("R7 mem_wr_en", mem_wr_en, exp_en);
    if (exp_en) begin
      chk("R7 addr pass", mem_wr_addr, addr);
      chk("R7 data pass", mem_wr_data, wd[7:0] ^ 8'h5A);
    end
    @(posedge clk);
    if (wr && sel == 0) pm = key_next(pm, wd, 'h56, 'hAE);
    else if (wr && sel == 1) dm = key_next(dm, wd, 'hAE, 'h56);
    else if (wr && sel == 2) begin
      if (!wd[1] && pm != 3) pm = 0;
      if (!wd[3] && dm != 3) dm = 0;
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; reg_wr = 0; mem_wr_req = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
    pm = 0; dm = 0;
  endtask

  initial begin
    #1_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    do_reset();
    #1;
    chk("R1 prog locked", prog_unlocked, 0);
    chk("R1 data locked", data_unlocked, 0);
    step(0, 0, 0, 1, 'h9000);
    step(0, 0, 0, 1, 'h0100);
    // R2 program unlock, R9 extra key writes ignored
    step(1, 0, 'h56, 0, 0);
    step(1, 0, 'hAE, 1, 'h8000);
    step(0, 0, 0, 1, 'h8000);
    step(1, 0, 'h00, 1, 'hFFFF);
    #1 chk("R9 still open", prog_unlocked, 1);
    step(0, 0, 0, 1, 'h7FFF);
    // R6 status bit set cannot open data; bit1 clear relocks program
    step(1, 2, 'hFF, 0, 0);
    #1 chk("R6 no set", data_unlocked, 0);
    step(1, 2, 'h08, 1, 'h8000);
    #1 chk("R6 relock prog", prog_unlocked, 0);
    // R6 pending first key discarded
    step(1, 0, 'h56, 0, 0);
    step(1, 2, 'h00, 0, 0);
    step(1, 0, 'hAE, 0, 0);
    #1 chk("R6 first key dropped", prog_unlocked, 0);
    // R4 program now failed: correct sequence ignored, status no help
    step(1, 0, 'h56, 0, 0);
    step(1, 0, 'hAE, 0, 0);
    step(1, 2, 'h00, 0, 0);
    step(1, 0, 'h56, 0, 0);
    step(1, 0, 'hAE, 1, 'hA000);
    #1 chk("R4 fail sticky", prog_unlocked, 0);
    // R3 data unlock independent, R5 unused select
    step(1, 1, 'hAE, 0, 0);
    step(1, 1, 'h56, 1, 'h0010);
    step(0, 2, 0, 1, 'h0010);
    step(1, 3, 'h00, 0, 0);
    step(0, 3, 0, 0, 0);
    #1 chk("R3 data open", data_unlocked, 1);
    step(1, 2, 'h02, 0, 0);
    #1 chk("R6 relock data", data_unlocked, 0);
    // R8 reset clears failure
    do_reset();
    step(1, 0, 'h56, 0, 0);
    step(1, 0, 'hAE, 0, 0);
    #1 chk("R8 reopen after reset", prog_unlocked, 1);
    // R4 wrong first key on data
    step(1, 1, 'h56, 0, 0);
    step(1, 1, 'hAE, 0, 0);
    step(1, 1, 'h56, 0, 0);
    #1 chk("R4 data failed", data_unlocked, 0);
    do_reset();
    for (int i = 0; i < 4000; i++) begin
      int sel, wd, addr;
      bit wr, mreq;
      lcg = lcg * 1103515245 + 12345;
      wr = lcg[20]; sel = lcg[22:21]; mreq = lcg[23];
      case (lcg[26:24])
        0, 1: wd = 'h56;
        2, 3: wd = 'hAE;
        4: wd = lcg[7:0];
        default: wd = 'h0A;
      endcase
      if (sel == 2 && lcg[27]) wd = 'hFF;
      addr = lcg[15:0] ^ {lcg[29], 15'd0};
      step(wr, sel, wd, mreq, addr);
      if (lcg[30:28] == 0 && lcg[19:16] == 0) do_reset();
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule